// File: doc/BRIEF.md
# Address-Collision Busy Arbiter

This block sits beside a two-port memory and decides who goes first when both ports reach for the same word. Each port presents a select and an address on every clock. When both ports are selected on the same address, the block grants the port whose access began in an earlier cycle. It drives an active-low busy toward the other port. The losing side uses busy to stall its access. Any slave memories that share the address range use the same busy lines as write inhibits, so all slices of a wide word follow one decision.

The decision looks only at selects and addresses. There is no read/write input, so reads and writes are arbitrated the same way. A port's arrival time is the cycle in which it started selecting its current address with no gap. When both ports arrive in the same cycle, a parameter picks the winner. By default the left port wins and the right port gets busy. A registered owner keeps the grant on one side for the whole of an ongoing contention. Busy therefore cannot change sides while both ports hold their addresses.

Top module: `port_collision_arbiter`

## Requirements
- R1: Each busy output is low only while both selects are high and the two addresses are equal. When that match holds, exactly one busy output is low.
- R2: busy_l_n and busy_r_n are never low in the same cycle.
- R3: Suppose one port has held the matching address selected since the previous cycle, and the other port selects it only in this cycle. Then the other port (the later arrival) receives busy in this same cycle.
- R4: If both ports start a match in the same cycle, the tie goes to the left port and busy_r_n is driven low. This is the default, TIE_LEFT=1.
- R5: While both ports keep the same selected, matching address from cycle to cycle, busy stays on the side chosen when the contention began. This holds even if the right port won.
- R6: Busy returns high in the same cycle the match ends. This happens when either select drops or when either address changes to a value that no longer matches.
- R7: While rst is high, both busy outputs are high. Arrival history is cleared, so a match present in the first cycle after reset is treated as simultaneous.
- R8: A match that moves, with both ports changing together to a new shared address, is arbitrated afresh as a simultaneous start.
- R9: Arrival by address counts like arrival by select. A port already selected that moves onto the other port's held address is the later arrival.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| sel_l | input | 1 | Left port select, active high |
| addr_l | input | ADDR_W | Left port address |
| sel_r | input | 1 | Right port select, active high |
| addr_r | input | ADDR_W | Right port address |
| busy_l_n | output | 1 | Busy to left port, active low |
| busy_r_n | output | 1 | Busy to right port, active low |

## Verification
A wrong arrival history makes the first cycle of a match grant the wrong side. A wrong owner register makes busy jump sides on the second cycle of a held contention. Both faults show at the busy pins within one or two cycles of the contention starting. Each scenario therefore checks the opening cycle and several held cycles, with left-first, right-first, tied and address-moved starts. It also checks that busy releases in the cycle the match ends.

// File: rtl/port_collision_arbiter_pkg.sv
package port_collision_arbiter_pkg;
   typedef enum logic [1:0] {
      OWN_NONE  = 2'd0,
      OWN_LEFT  = 2'd1,
      OWN_RIGHT = 2'd2
   } owner_t;
endpackage

// File: rtl/pca_arrival_track.sv
// Remembers last cycle's select and address of one port; reports whether
// the current selection was already in place a cycle earlier.
module pca_arrival_track #(
   parameter int ADDR_W = 11
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              sel,
   input  logic [ADDR_W-1:0] addr,
   output logic              held
);
   logic              sel_q;
   logic [ADDR_W-1:0] addr_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         sel_q  <= 1'b0;
         addr_q <= '0;
      end else begin
         sel_q  <= sel;
         addr_q <= addr;
      end
   end

   assign held = sel && sel_q && (addr == addr_q);
endmodule

// File: rtl/pca_match.sv
module pca_match #(
   parameter int ADDR_W = 11
) (
   input  logic              sel_l,
   input  logic [ADDR_W-1:0] addr_l,
   input  logic              sel_r,
   input  logic [ADDR_W-1:0] addr_r,
   output logic              hit
);
   assign hit = sel_l && sel_r && (addr_l == addr_r);
endmodule

// File: rtl/pca_owner.sv
// Picks the grant holder; keeps it while both sides hold the same match.
module pca_owner
   import port_collision_arbiter_pkg::*;
#(
   parameter bit TIE_LEFT = 1'b1
) (
   input  logic   clk,
   input  logic   rst,
   input  logic   hit,
   input  logic   held_l,
   input  logic   held_r,
   output owner_t grant
);
   owner_t tie_side;
   owner_t grant_q;

   generate
      if (TIE_LEFT) begin : g_tie_left
         assign tie_side = OWN_LEFT;
      end else begin : g_tie_right
         assign tie_side = OWN_RIGHT;
      end
   endgenerate

   always_comb begin
      if (!hit)
         grant = OWN_NONE;
      else if (held_l && held_r && grant_q != OWN_NONE)
         grant = grant_q;
      else if (held_l && !held_r)
         grant = OWN_LEFT;
      else if (held_r && !held_l)
         grant = OWN_RIGHT;
      else
         grant = tie_side;
   end

   always_ff @(posedge clk) begin
      if (rst) grant_q <= OWN_NONE;
      else     grant_q <= grant;
   end
endmodule

// File: rtl/port_collision_arbiter.sv
module port_collision_arbiter
   import port_collision_arbiter_pkg::*;
#(
   parameter int ADDR_W   = 11,
   parameter bit TIE_LEFT = 1'b1
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              sel_l,
   input  logic [ADDR_W-1:0] addr_l,
   input  logic              sel_r,
   input  logic [ADDR_W-1:0] addr_r,
   output logic              busy_l_n,
   output logic              busy_r_n
);
   generate
      if (ADDR_W < 1) begin : g_bad_width
         $error("port_collision_arbiter: ADDR_W must be at least 1");
      end
   endgenerate

   logic   held_l, held_r, hit;
   owner_t grant;

   pca_arrival_track #(.ADDR_W(ADDR_W)) u_trk_l (
      .clk(clk), .rst(rst), .sel(sel_l), .addr(addr_l), .held(held_l));
   pca_arrival_track #(.ADDR_W(ADDR_W)) u_trk_r (
      .clk(clk), .rst(rst), .sel(sel_r), .addr(addr_r), .held(held_r));

   pca_match #(.ADDR_W(ADDR_W)) u_match (
      .sel_l(sel_l), .addr_l(addr_l), .sel_r(sel_r), .addr_r(addr_r), .hit(hit));

   pca_owner #(.TIE_LEFT(TIE_LEFT)) u_owner (
      .clk(clk), .rst(rst), .hit(hit), .held_l(held_l), .held_r(held_r),
      .grant(grant));

   // Push-pull outputs: always driven, idle high during reset.
   assign busy_l_n = rst || (grant != OWN_RIGHT);
   assign busy_r_n = rst || (grant != OWN_LEFT);
endmodule

// File: rtl/port_collision_arbiter_chk.sv
module port_collision_arbiter_chk #(
   parameter int ADDR_W   = 11,
   parameter bit TIE_LEFT = 1'b1
) (
   input logic              clk,
   input logic              rst,
   input logic              sel_l,
   input logic [ADDR_W-1:0] addr_l,
   input logic              sel_r,
   input logic [ADDR_W-1:0] addr_r,
   input logic              busy_l_n,
   input logic              busy_r_n
);
   logic              psl_q, psr_q, pbl_q;
   logic [ADDR_W-1:0] pal_q, par_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         psl_q <= 1'b0; psr_q <= 1'b0; pbl_q <= 1'b1;
         pal_q <= '0;   par_q <= '0;
      end else begin
         psl_q <= sel_l; psr_q <= sel_r; pbl_q <= busy_l_n;
         pal_q <= addr_l; par_q <= addr_r;
      end
   end

   logic same, st_l, st_r;
   assign same = sel_l && sel_r && (addr_l == addr_r);
   assign st_l = sel_l && psl_q && (addr_l == pal_q);
   assign st_r = sel_r && psr_q && (addr_r == par_q);

   a_r1_idle_without_match: assert property (@(posedge clk) disable iff (rst)
      !same |-> (busy_l_n && busy_r_n));
   a_r1_match_one_side: assert property (@(posedge clk) disable iff (rst)
      same |-> (busy_l_n != busy_r_n));
   a_r2_never_both: assert property (@(posedge clk) disable iff (rst)
      !(!busy_l_n && !busy_r_n));
   a_r3_left_earlier: assert property (@(posedge clk) disable iff (rst)
      (same && st_l && !st_r) |-> !busy_r_n);
   a_r3_right_earlier: assert property (@(posedge clk) disable iff (rst)
      (same && st_r && !st_l) |-> !busy_l_n);
   a_r4_tie_side: assert property (@(posedge clk) disable iff (rst)
      (same && !st_l && !st_r) |-> (TIE_LEFT ? !busy_r_n : !busy_l_n));
   a_r5_owner_held: assert property (@(posedge clk) disable iff (rst)
      (same && st_l && st_r) |-> (busy_l_n == pbl_q));
   a_r7_reset_idle: assert property (@(posedge clk)
      rst |-> (busy_l_n && busy_r_n));
endmodule

bind port_collision_arbiter port_collision_arbiter_chk #(
   .ADDR_W(ADDR_W), .TIE_LEFT(TIE_LEFT)
) u_chk (
   .clk(clk), .rst(rst), .sel_l(sel_l), .addr_l(addr_l),
   .sel_r(sel_r), .addr_r(addr_r), .busy_l_n(busy_l_n), .busy_r_n(busy_r_n));

// File: tb/port_collision_arbiter_bench.sv
module port_collision_arbiter_bench;
   localparam int AW = 11;

   logic          clk = 1'b0;
   logic          rst = 1'b1;
   logic          sel_l = 1'b0, sel_r = 1'b0;
   logic [AW-1:0] addr_l = '0, addr_r = '0;
   logic          busy_l_n, busy_r_n;
   int            checks = 0;
   int            errors = 0;
   bit            done = 1'b0;

   always #10 clk = ~clk;   // 50 MHz

   port_collision_arbiter #(.ADDR_W(AW), .TIE_LEFT(1'b1)) u_port_collision_arbiter (
      .clk(clk), .rst(rst), .sel_l(sel_l), .addr_l(addr_l),
      .sel_r(sel_r), .addr_r(addr_r), .busy_l_n(busy_l_n), .busy_r_n(busy_r_n));

   // One cycle: drive at the falling edge, sample 5 ns later (before rising edge).
   task automatic cyc(input logic sl, input logic [AW-1:0] al,
                      input logic sr, input logic [AW-1:0] ar);
      @(negedge clk);
      sel_l = sl; addr_l = al; sel_r = sr; addr_r = ar;
      #5;
   endtask

   task automatic chk(input string req, input logic exp_l, input logic exp_r);
      checks++;
      if (busy_l_n !== exp_l || busy_r_n !== exp_r) begin
         errors++;
         $display("FAIL %s: busy_l_n/busy_r_n = %b%b, expected %b%b",
                  req, busy_l_n, busy_r_n, exp_l, exp_r);
      end
   endtask

   task automatic t_reset;
      cyc(1, 11'h7FE, 1, 11'h7FE);
      chk("R7 idle during reset", 1, 1);
      cyc(1, 11'h7FE, 1, 11'h7FE);
      chk("R7 idle during reset held", 1, 1);
      @(negedge clk); rst = 1'b0; #5;
      chk("R7 first cycle after reset is a tie (right busy)", 1, 0);
      cyc(0, 0, 0, 0);
      chk("R6 clear on both deselect", 1, 1);
   endtask

   task automatic t_no_match;
      cyc(1, 11'h010, 1, 11'h011);
      chk("R1 different addresses", 1, 1);
      cyc(1, 11'h020, 0, 11'h020);
      chk("R1 right not selected", 1, 1);
      cyc(0, 11'h020, 1, 11'h020);
      chk("R1 left not selected", 1, 1);
      cyc(0, 0, 0, 0);
   endtask

   task automatic t_left_first;
      cyc(1, 11'h123, 0, 11'h123);
      chk("R3 left alone", 1, 1);
      cyc(1, 11'h123, 1, 11'h123);
      chk("R3 left earlier, right busy", 1, 0);
      for (int i = 0; i < 3; i++) begin
         cyc(1, 11'h123, 1, 11'h123);
         chk("R5 left grant held", 1, 0);
      end
      cyc(1, 11'h123, 0, 11'h123);
      chk("R6 clear when loser deselects", 1, 1);
      cyc(0, 0, 0, 0);
   endtask

   task automatic t_right_first;
      cyc(0, 11'h2AA, 1, 11'h2AA);
      cyc(1, 11'h2AA, 1, 11'h2AA);
      chk("R3 right earlier, left busy", 0, 1);
      for (int i = 0; i < 4; i++) begin
         cyc(1, 11'h2AA, 1, 11'h2AA);
         chk("R5 right grant held, no flip to left", 0, 1);
      end
      // both move together to a new shared address
      cyc(1, 11'h2AB, 1, 11'h2AB);
      chk("R8 moved contention re-arbitrated as tie", 1, 0);
      cyc(0, 11'h2AB, 1, 11'h2AB);
      chk("R6 clear when winner deselects", 1, 1);
      cyc(0, 0, 0, 0);
   endtask

   task automatic t_addr_move;
      cyc(1, 11'h400, 1, 11'h401);
      chk("R1 both selected, no match", 1, 1);
      cyc(1, 11'h400, 1, 11'h400);
      chk("R9 right moved onto left address, right busy", 1, 0);
      cyc(1, 11'h402, 1, 11'h400);
      chk("R6 clear when winner address moves", 1, 1);
      cyc(1, 11'h400, 1, 11'h400);
      chk("R9 left moved onto right address, left busy", 0, 1);
      cyc(0, 0, 0, 0);
   endtask

   task automatic t_tie;
      cyc(1, 11'h7FF, 1, 11'h7FF);
      chk("R4 simultaneous start, right busy", 1, 0);
      cyc(1, 11'h7FF, 1, 11'h7FF);
      chk("R5 tie grant held", 1, 0);
      cyc(1, 11'h000, 1, 11'h7FF);
      chk("R6 clear on address mismatch", 1, 1);
      cyc(0, 0, 0, 0);
      cyc(1, 11'h000, 1, 11'h000);
      chk("R4 tie at address zero", 1, 0);
      if (!(busy_l_n && busy_r_n)) begin
         checks++;
         if (!busy_l_n && !busy_r_n) begin
            errors++;
            $display("FAIL R2: both busy low, expected at most one");
         end
      end
      cyc(0, 0, 0, 0);
   endtask

   initial begin
      t_reset();
      t_no_match();
      t_left_first();
      t_right_first();
      t_addr_move();
      t_tie();
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: run did not end, expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end
endmodule